// File: doc/BRIEF.md
# Smart Card Character Receiver

This block takes a single asynchronous half-duplex data line and turns each incoming character into a byte. A character has one low start bit, eight data bits and one parity bit. The block runs on a basic clock, and each bit lasts a fixed number of basic clocks chosen by a two-bit select. A falling edge on the idle line starts a character and restarts the bit timing. Each bit is then sampled at the middle of its period.

A per-character convention setting controls two things: the order in which bits are assembled (least significant first or most significant first) and whether the eight data bits are inverted. A separate odd/even select sets which parity result counts as correct, so both conventions check the same line-level rule.

When a parity mismatch is found, the block only raises a sticky flag. It never drives anything onto the line. A completed character sets a receive-full flag, and the byte stays in the output register until the consumer acknowledges it.

Top module: `sc_char_rx`

## Requirements
- R1: After reset, `rx_full` is 0, `par_err` is 0 and `rx_byte` is 0x00.
- R2: The bit period in basic clocks follows `clk_sel`: 0 gives 32, 1 gives 64, 2 gives 372 and 3 gives 256. Each bit is sampled at half its period after the start edge.
- R3: A character begins on a high-to-low transition of `rxd` while idle. If the start bit reads high at its mid-point, the event is discarded as a glitch: no byte is delivered and the receiver waits for a new falling edge.
- R4: With `msb_first`=0 and `data_inv`=0, the first data bit received becomes bit 0 of `rx_byte` and no bit is inverted. The line levels high,high,low,high,high,high,low,low decode to 0x3B.
- R5: With `msb_first`=1 and `data_inv`=1, the first data bit received becomes bit 7 and every data bit is inverted. The line levels high,high,low,low,low,low,low,low decode to 0x3F. The two controls also work on their own.
- R6: `par_err` is set when (XOR of the eight decoded data bits) XOR (parity line level) differs from `odd_par`. `data_inv` never alters the parity bit.
- R7: `par_err` stays set until a one-cycle `per_clr` pulse clears it.
- R8: `rx_full` is set when the parity bit has been sampled and cleared by a `rd_done` pulse. While `rx_full` is 1, `rx_byte` does not change, and a character completing in that time is dropped. Its parity result is still recorded.
- R9: `err_sig` reads 0 and `line_oe` stays 0 at all times, including after a parity error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | basic clock |
| rst_n | input | 1 | active-low asynchronous reset |
| clk_sel | input | 2 | basic clocks per bit: 32/64/372/256 |
| msb_first | input | 1 | assemble first data bit as bit 7 |
| data_inv | input | 1 | invert the eight data bits |
| odd_par | input | 1 | expected XOR of decoded data and parity bit |
| rxd | input | 1 | serial data line |
| rd_done | input | 1 | consumer has taken `rx_byte` |
| per_clr | input | 1 | clear pulse for the parity error flag |
| rx_byte | output | 8 | received character |
| rx_full | output | 1 | character waiting |
| par_err | output | 1 | sticky parity error |
| err_sig | output | 1 | error-signal status, always 0 |
| line_oe | output | 1 | drive enable for the line, always 0 |

## Verification
The assertions assume that `clk_sel`, `msb_first`, `data_inv` and `odd_par` are stable from the start edge until the parity sample. They also assume that `per_clr` is not pulsed in the same cycle that a character completes. The stimulus changes these controls, and pulses `rd_done` and `per_clr`, only after a full stop period of high line. Every bit is held for exactly the selected period, so the receiver's mid-bit sample falls well inside each bit. The one exception is the short glitch pulse, which ends before that sample is taken.

// File: rtl/sc_char_rx.sv
module sc_char_rx #(
  parameter int PER0 = 32,
  parameter int PER1 = 64,
  parameter int PER2 = 372,
  parameter int PER3 = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] clk_sel,
  input  logic       msb_first,
  input  logic       data_inv,
  input  logic       odd_par,
  input  logic       rxd,
  input  logic       rd_done,
  input  logic       per_clr,
  output logic [7:0] rx_byte,
  output logic       rx_full,
  output logic       par_err,
  output logic       err_sig,
  output logic       line_oe
);
  localparam int PM01 = (PER0 > PER1) ? PER0 : PER1;
  localparam int PM23 = (PER2 > PER3) ? PER2 : PER3;
  localparam int PMAX = (PM01 > PM23) ? PM01 : PM23;
  localparam int CW   = $clog2(PMAX + 1);

  logic [CW-1:0] per, half, cnt;
  logic [3:0]    idx;
  logic [7:0]    shreg;
  logic          r1, r2, prev, busy, pacc;
  logic          smp, done, bad, dbit;

  always_comb begin
    case (clk_sel)
      2'd0:    per = CW'(PER0);
      2'd1:    per = CW'(PER1);
      2'd2:    per = CW'(PER2);
      default: per = CW'(PER3);
    endcase
  end

  assign half = per >> 1;
  assign smp  = busy && (cnt == half);
  assign done = smp && (idx == 4'd9);
  assign bad  = pacc ^ r2 ^ odd_par;
  assign dbit = r2 ^ data_inv;

  assign err_sig = 1'b0;
  assign line_oe = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1    <= 1'b1;
      r2    <= 1'b1;
      prev  <= 1'b1;
      busy  <= 1'b0;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      pacc  <= 1'b0;
    end else begin
      r1   <= rxd;
      r2   <= r1;
      prev <= r2;
      if (!busy) begin
        if (prev && !r2) begin
          busy <= 1'b1;
          cnt  <= '0;
          idx  <= '0;
          pacc <= 1'b0;
        end
      end else begin
        if (cnt == per - 1'b1) begin
          cnt <= '0;
          idx <= idx + 4'd1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        if (smp) begin
          if (idx == 4'd0) begin
            if (r2) busy <= 1'b0;
          end else if (idx <= 4'd8) begin
            shreg <= msb_first ? {shreg[6:0], dbit} : {dbit, shreg[7:1]};
            pacc  <= pacc ^ r2;
          end else begin
            busy <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0;
      rx_full <= 1'b0;
      par_err <= 1'b0;
    end else begin
      if (done && !rx_full) rx_byte <= shreg;
      if (done)         rx_full <= 1'b1;
      else if (rd_done) rx_full <= 1'b0;
      if (done && bad)  par_err <= 1'b1;
      else if (per_clr) par_err <= 1'b0;
    end
  end

  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < per));
  a_r3_glitch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (smp && idx == 4'd0 && r2) |=> !busy);
  a_r8_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |=> $stable(rx_byte));
  a_r8_full_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(done));
  a_r6_perr_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> $past(done));
  a_r7_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !per_clr) |=> par_err);
  a_r7_perr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (per_clr && !done) |=> !par_err);
endmodule

// File: tb/test_sc_char_rx.sv
module test_sc_char_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic msb_first = 1'b0, data_inv = 1'b0, odd_par = 1'b0;
  logic rxd = 1'b1, rd_done = 1'b0, per_clr = 1'b0;
  logic [7:0] rx_byte;
  logic rx_full, par_err, err_sig, line_oe;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sc_char_rx i_sc_char_rx (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .msb_first(msb_first),
    .data_inv(data_inv), .odd_par(odd_par), .rxd(rxd), .rd_done(rd_done),
    .per_clr(per_clr), .rx_byte(rx_byte), .rx_full(rx_full),
    .par_err(par_err), .err_sig(err_sig), .line_oe(line_oe));

  // {sel, msb_first, data_inv, odd_par, line bits (bit0 sent first), parity, exp byte, exp perr}
  localparam logic [22:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 8'h3B, 1'b1, 8'h3B, 1'b0},
    {2'd1, 1'b1, 1'b1, 1'b1, 8'h03, 1'b1, 8'h3F, 1'b0},
    {2'd2, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 8'hA5, 1'b0},
    {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b1, 8'hA5, 1'b1},
    {2'd0, 1'b1, 1'b1, 1'b1, 8'h03, 1'b0, 8'h3F, 1'b1},
    {2'd0, 1'b1, 1'b0, 1'b0, 8'h01, 1'b1, 8'h80, 1'b0},
    {2'd1, 1'b0, 1'b1, 1'b0, 8'h0F, 1'b0, 8'hF0, 1'b0},
    {2'd2, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00, 1'b0}
  };

  function automatic int per_of(input logic [1:0] s);
    case (s)
      2'd0: return 32;
      2'd1: return 64;
      2'd2: return 372;
      default: return 256;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] line, input logic par, input int p);
    hold(1'b0, p);
    for (int i = 0; i < 8; i++) hold(line[i], p);
    hold(par, p);
    hold(1'b1, 2 * p);
  endtask

  task automatic pulse_clear();
    rd_done = 1'b1; per_clr = 1'b1;
    @(negedge clk);
    rd_done = 1'b0; per_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_full == 1'b0, "R1 full", rx_full, 0);
    check(par_err == 1'b0, "R1 perr", par_err, 0);
    check(rx_byte == 8'h00, "R1 byte", rx_byte, 0);

    for (int v = 0; v < 8; v++) begin
      int p;
      {clk_sel, msb_first, data_inv, odd_par} = VEC[v][22:18];
      p = per_of(VEC[v][22:21]);
      hold(1'b1, p);
      send(VEC[v][17:10], VEC[v][9], p);
      check(rx_full == 1'b1, "R2/R8 full after frame", rx_full, 1);
      check(rx_byte == VEC[v][8:1], "R4/R5 byte", rx_byte, VEC[v][8:1]);
      check(par_err == VEC[v][0], "R6 parity", par_err, VEC[v][0]);
      check(err_sig == 1'b0 && line_oe == 1'b0, "R9 no error signal", {err_sig, line_oe}, 0);
      pulse_clear();
      check(rx_full == 1'b0, "R8 rd_done clears", rx_full, 0);
      check(par_err == 1'b0, "R7 per_clr clears", par_err, 0);
    end

    // R7: flag stays set across idle time without a clear
    clk_sel = 2'd0; msb_first = 1'b0; data_inv = 1'b0; odd_par = 1'b0;
    send(8'hA5, 1'b1, 32);
    rd_done = 1'b1; @(negedge clk); rd_done = 1'b0;
    repeat (100) @(negedge clk);
    check(par_err == 1'b1, "R7 sticky", par_err, 1);
    pulse_clear();

    // R3: short low glitch discarded
    hold(1'b0, 8);
    hold(1'b1, 200);
    check(rx_full == 1'b0, "R3 glitch ignored", rx_full, 0);
    send(8'h3B, 1'b1, 32);
    check(rx_full == 1'b1 && rx_byte == 8'h3B, "R3 recovers after glitch", rx_byte, 8'h3B);

    // R8: frames while full are dropped, parity still recorded
    send(8'hA5, 1'b0, 32);
    check(rx_byte == 8'h3B, "R8 hold while full", rx_byte, 8'h3B);
    check(par_err == 1'b0, "R6 good parity while full", par_err, 0);
    send(8'hA5, 1'b1, 32);
    check(rx_byte == 8'h3B, "R8 hold on second overrun", rx_byte, 8'h3B);
    check(par_err == 1'b1, "R8 parity recorded while full", par_err, 1);
    check(line_oe == 1'b0, "R9 line never driven", line_oe, 0);
    pulse_clear();

    // R2: completion lands in the parity bit, after its mid-point
    hold(1'b0, 32);
    for (int i = 0; i < 8; i++) hold(1'b1, 32);
    hold(1'b0, 8);
    check(rx_full == 1'b0, "R2 not done early", rx_full, 0);
    hold(1'b0, 24);
    check(rx_full == 1'b1, "R2 done by end of parity", rx_full, 1);
    check(rx_byte == 8'hFF, "R4 all ones", rx_byte, 8'hFF);
    hold(1'b1, 64);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule